// File: doc/BRIEF.md
# Three-dimensional DMA address generator

The block walks the byte addresses of one DMA transfer. A transfer is described by a parameter set of eight 32-bit words. The set gives a byte count per array (A), arrays per frame (B) and frames per block (C). It also gives separate signed array and frame strides for the source and the destination, a B-count reload value and a few option bits. The set is presented on a wide load port and captured in one cycle.

Each synchronization event releases a burst of beats on a valid/ready output. Each beat carries a source address, a destination address, the array length in bytes and the 3-bit FIFO width field. In A-synchronized mode an event releases one array. In AB-synchronized mode it releases a whole frame. After the final beat of the block is accepted, the block reports completion. Any later event is refused with a one-cycle error pulse. Memory access, linking of parameter sets and bus protocol are left to neighbouring logic.

Top module: `dma3d_walker`

## Requirements
- R1: After reset, `out_valid` and `err_o` are low and `done_o` is high, because no block is pending.
- R2: Word layout on `pset_i` (word k occupies bits 32k+31:32k):
  - word 0 holds the options: bit 0 = AB-synchronized, bit 1 = hold source address, bit 2 = hold destination address, bits 10:8 = FIFO width.
  - word 1 = source, word 2 = {B count, A count}, word 3 = destination.
  - word 4 = {dest array stride, source array stride}, word 5 = {B reload, link}, word 6 = {dest frame stride, source frame stride}.
  - word 7 bits 15:0 = C count.
  - `load_i` captures the set only when no event is in progress, and it clears `done_o`. A load while a burst is running is ignored.
- R3: In A-synchronized mode, each accepted event yields exactly one beat of length A count. Within a frame, each address moves by its array stride from one array to the next.
- R4: In A-synchronized mode, after the last array of a frame each address becomes that array's start plus its frame stride. Every frame after the first holds B-reload arrays.
- R5: In AB-synchronized mode, each accepted event yields every array of one frame (B count beats). The next frame starts at the previous frame's start plus the frame stride, and every frame holds B count arrays.
- R6: With a hold bit set, that side's address stays at its start value for the whole block. With both strides zero, every beat uses the same address.
- R7: `done_o` rises in the cycle after the handshake of the final beat of the last frame. No beat is offered while `done_o` is high.
- R8: An event while `done_o` is high raises `err_o` for one cycle per event and produces no beat. An event during a running burst is ignored.
- R9: While `out_valid` is high and `out_ready` is low, the outputs hold their values.
- R10: `out_width` reflects option bits 10:8, and `out_len` reflects the A count of the loaded set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture the parameter set |
| pset_i | input | 256 | Eight 32-bit parameter words |
| evt_i | input | 1 | Synchronization event |
| out_ready | input | 1 | Consumer accepts the beat |
| out_valid | output | 1 | Beat available |
| out_src | output | 32 | Source byte address |
| out_dst | output | 32 | Destination byte address |
| out_len | output | 16 | Bytes in the array |
| out_width | output | 3 | FIFO width field |
| done_o | output | 1 | Block complete |
| err_o | output | 1 | Event refused because the block is complete |

## Verification
The bench works through several corner cases:
- The frame boundary in both sync modes with negative strides, where a design that used the frame start in A mode or the array start in AB mode would jump to the wrong address.
- A-mode frames after the first, which must use the reload count. A design that kept the original B count would offer extra arrays and finish late.
- Events and loads that arrive during a burst or after completion. A design that accepted them would restart the walk, corrupt the addresses or miss the error pulse.
- Constant-address and zero-stride blocks, and stalls on ready. These expose an address that drifts or a beat that changes while it waits.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 8;
    localparam int CNT_W   = 16;
    localparam int FW_W    = 3;

    localparam int W_OPT  = 0;
    localparam int W_SRC  = 1;
    localparam int W_CNT  = 2;
    localparam int W_DST  = 3;
    localparam int W_BIDX = 4;
    localparam int W_LINK = 5;
    localparam int W_CIDX = 6;
    localparam int W_CCNT = 7;

    localparam int OPT_AB    = 0;
    localparam int OPT_SHOLD = 1;
    localparam int OPT_DHOLD = 2;
    localparam int OPT_FW_LO = 8;

    typedef struct packed {
        logic                 ab;
        logic [1:0]           hold;   // [0] source, [1] destination
        logic [FW_W-1:0]      fwidth;
        logic [CNT_W-1:0]     acnt;
        logic [CNT_W-1:0]     bcnt;
        logic [CNT_W-1:0]     rld;
        logic [CNT_W-1:0]     ccnt;
        logic [1:0][WORD_W-1:0] base;   // [0] source, [1] destination
        logic [1:0][CNT_W-1:0]  bidx;
        logic [1:0][CNT_W-1:0]  cidx;
    } pset_t;

    function automatic logic [WORD_W-1:0] word_at(input logic [N_WORDS*WORD_W-1:0] raw,
                                                  input int idx);
        return raw[idx*WORD_W +: WORD_W];
    endfunction

    function automatic pset_t unpack_pset(input logic [N_WORDS*WORD_W-1:0] raw);
        pset_t p;
        logic [WORD_W-1:0] opt;
        opt       = word_at(raw, W_OPT);
        p.ab      = opt[OPT_AB];
        p.hold[0] = opt[OPT_SHOLD];
        p.hold[1] = opt[OPT_DHOLD];
        p.fwidth  = opt[OPT_FW_LO +: FW_W];
        p.acnt    = word_at(raw, W_CNT)[CNT_W-1:0];
        p.bcnt    = word_at(raw, W_CNT)[WORD_W-1:CNT_W];
        p.rld     = word_at(raw, W_LINK)[WORD_W-1:CNT_W];
        p.ccnt    = word_at(raw, W_CCNT)[CNT_W-1:0];
        p.base[0] = word_at(raw, W_SRC);
        p.base[1] = word_at(raw, W_DST);
        p.bidx[0] = word_at(raw, W_BIDX)[CNT_W-1:0];
        p.bidx[1] = word_at(raw, W_BIDX)[WORD_W-1:CNT_W];
        p.cidx[0] = word_at(raw, W_CIDX)[CNT_W-1:0];
        p.cidx[1] = word_at(raw, W_CIDX)[WORD_W-1:CNT_W];
        return p;
    endfunction
endpackage

// File: rtl/dma3d_side.sv
module dma3d_side #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [ADDR_W-1:0] frm_i,
    input  logic [IDX_W-1:0]  bidx_i,
    input  logic [IDX_W-1:0]  cidx_i,
    input  logic              hold_i,
    input  logic              eof_i,
    input  logic              ab_i,
    output logic [ADDR_W-1:0] nxt_cur_o,
    output logic [ADDR_W-1:0] nxt_frm_o
);
    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] bstep;
    logic [ADDR_W-1:0] cstep;
    logic [ADDR_W-1:0] frame_from;

    assign bstep = {{EXT_W{bidx_i[IDX_W-1]}}, bidx_i};
    assign cstep = {{EXT_W{cidx_i[IDX_W-1]}}, cidx_i};
    // AB mode measures the frame stride from the frame start, A mode from the array start
    assign frame_from = ab_i ? frm_i : cur_i;

    always_comb begin
        nxt_cur_o = cur_i;
        nxt_frm_o = frm_i;
        if (!hold_i) begin
            if (eof_i) begin
                nxt_cur_o = frame_from + cstep;
                nxt_frm_o = frame_from + cstep;
            end else begin
                nxt_cur_o = cur_i + bstep;
            end
        end
    end
endmodule

// File: rtl/dma3d_count.sv
module dma3d_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ld_bcnt_i,
    input  logic [CNT_W-1:0] ld_ccnt_i,
    input  logic [CNT_W-1:0] full_bcnt_i,
    input  logic [CNT_W-1:0] rld_i,
    input  logic             ab_i,
    input  logic             evt_i,
    input  logic             beat_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             eof_o
);
    typedef struct packed {
        logic [CNT_W-1:0] bcnt;
        logic [CNT_W-1:0] ccnt;
        logic             busy;
        logic             done;
        logic             err;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (beat_i) begin
            if (st_q.bcnt > ONE) begin
                st_d.bcnt = st_q.bcnt - ONE;
                if (!ab_i) begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.bcnt = ab_i ? full_bcnt_i : rld_i;
                st_d.ccnt = st_q.ccnt - ONE;
                st_d.busy = 1'b0;
                if (st_q.ccnt <= ONE) begin
                    st_d.done = 1'b1;
                end
            end
        end else if (load_i) begin
            st_d.bcnt = ld_bcnt_i;
            st_d.ccnt = ld_ccnt_i;
            st_d.busy = 1'b0;
            st_d.done = 1'b0;
        end else if (evt_i && !st_q.busy) begin
            if (st_q.done) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{bcnt: '0, ccnt: '0, busy: 1'b0, done: 1'b1, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
    assign eof_o  = (st_q.bcnt <= ONE);
endmodule

// File: rtl/dma3d_walker.sv
module dma3d_walker
    import dma3d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [N_WORDS*WORD_W-1:0]  pset_i,
    input  logic                       evt_i,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [ADDR_W-1:0]          out_src,
    output logic [ADDR_W-1:0]          out_dst,
    output logic [CNT_W-1:0]           out_len,
    output logic [FW_W-1:0]            out_width,
    output logic                       done_o,
    output logic                       err_o
);
    localparam int N_SIDES = 2;

    typedef struct packed {
        pset_t                          pset;
        logic [N_SIDES-1:0][ADDR_W-1:0] cur;
        logic [N_SIDES-1:0][ADDR_W-1:0] frm;
    } walk_st_t;

    walk_st_t w_d, w_q;
    pset_t    pset_new;
    logic     busy;
    logic     eof;
    logic     load_take;
    logic     beat;
    logic [N_SIDES-1:0][ADDR_W-1:0] nxt_cur;
    logic [N_SIDES-1:0][ADDR_W-1:0] nxt_frm;
    logic [N_SIDES-1:0]             hold_q;

    assign pset_new  = unpack_pset(pset_i);
    assign load_take = load_i && !busy;
    assign beat      = busy && out_ready;
    assign hold_q    = w_q.pset.hold;

    dma3d_count #(.CNT_W(CNT_W)) i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_take),
        .ld_bcnt_i  (pset_new.bcnt),
        .ld_ccnt_i  (pset_new.ccnt),
        .full_bcnt_i(w_q.pset.bcnt),
        .rld_i      (w_q.pset.rld),
        .ab_i       (w_q.pset.ab),
        .evt_i      (evt_i),
        .beat_i     (beat),
        .busy_o     (busy),
        .done_o     (done_o),
        .err_o      (err_o),
        .eof_o      (eof)
    );

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        dma3d_side #(.ADDR_W(ADDR_W), .IDX_W(CNT_W)) i_side (
            .cur_i    (w_q.cur[g]),
            .frm_i    (w_q.frm[g]),
            .bidx_i   (w_q.pset.bidx[g]),
            .cidx_i   (w_q.pset.cidx[g]),
            .hold_i   (w_q.pset.hold[g]),
            .eof_i    (eof),
            .ab_i     (w_q.pset.ab),
            .nxt_cur_o(nxt_cur[g]),
            .nxt_frm_o(nxt_frm[g])
        );
    end

    always_comb begin
        w_d = w_q;
        if (load_take) begin
            w_d.pset = pset_new;
            for (int s = 0; s < N_SIDES; s++) begin
                w_d.cur[s] = pset_new.base[s][ADDR_W-1:0];
                w_d.frm[s] = pset_new.base[s][ADDR_W-1:0];
            end
        end else if (beat) begin
            w_d.cur = nxt_cur;
            w_d.frm = nxt_frm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign out_valid = busy;
    assign out_src   = w_q.cur[0];
    assign out_dst   = w_q.cur[1];
    assign out_len   = w_q.pset.acnt;
    assign out_width = w_q.pset.fwidth;
endmodule

// File: rtl/dma3d_chk.sv
module dma3d_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_take,
    input logic              evt_i,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_src,
    input logic [ADDR_W-1:0] out_dst,
    input logic              done_o,
    input logic              err_o,
    input logic [1:0]        hold_q
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst)); // R9
    AST_IDLE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid); // R7
    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(out_valid && out_ready)); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(evt_i && done_o && !load_take)); // R8
    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q[0] && !load_take |=> $stable(out_src)); // R6
    AST_DST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q[1] && !load_take |=> $stable(out_dst)); // R6
endmodule

bind dma3d_walker dma3d_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_take(load_take),
    .evt_i    (evt_i),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_src  (out_src),
    .out_dst  (out_dst),
    .done_o   (done_o),
    .err_o    (err_o),
    .hold_q   (hold_q)
);

// File: tb/test_dma3d_walker.sv
module test_dma3d_walker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [255:0] pset_i = '0;
    logic         evt_i = 1'b0;
    logic         out_ready = 1'b1;
    logic         out_valid;
    logic [31:0]  out_src, out_dst;
    logic [15:0]  out_len;
    logic [2:0]   out_width;
    logic         done_o, err_o;

    always #4 clk = ~clk;

    dma3d_walker i_dma3d_walker (.*);

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    live    = 1'b0;

    // behavioural reference
    bit          m_busy = 0, m_done = 1, m_err = 0;
    int          m_left = 0;
    logic [15:0] m_len = 0;
    logic [2:0]  m_width = 0;
    logic [63:0] beat_q[$];
    int          ev_q[$];

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic build(input logic [255:0] p);
        logic [31:0] opt, s_a, d_a, s_f, d_f;
        int A, B, C, RL, nb;
        bit ab, sh, dh;
        opt = p[31:0];
        ab = opt[0]; sh = opt[1]; dh = opt[2];
        A = p[79:64]; B = p[95:80]; RL = p[191:176]; C = p[239:224];
        m_len = p[79:64]; m_width = opt[10:8];
        s_f = p[63:32]; d_f = p[127:96];
        s_a = s_f; d_a = d_f;
        beat_q.delete(); ev_q.delete();
        for (int c = 0; c < C; c++) begin
            nb = (ab || c == 0) ? B : RL;
            for (int b = 0; b < nb; b++) begin
                if (ab) begin
                    s_a = sh ? p[63:32]  : s_f + sx(p[143:128]) * b;
                    d_a = dh ? p[127:96] : d_f + sx(p[159:144]) * b;
                end
                beat_q.push_back({s_a, d_a});
                if (!ab) begin
                    ev_q.push_back(1);
                    if (b == nb - 1) begin
                        if (!sh) s_a = s_a + sx(p[207:192]);
                        if (!dh) d_a = d_a + sx(p[223:208]);
                    end else begin
                        if (!sh) s_a = s_a + sx(p[143:128]);
                        if (!dh) d_a = d_a + sx(p[159:144]);
                    end
                end
            end
            if (ab) begin
                ev_q.push_back(nb);
                if (!sh) s_f = s_f + sx(p[207:192]);
                if (!dh) d_f = d_f + sx(p[223:208]);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 1; m_err = 0; m_left = 0;
        end else begin
            bit pre_busy;
            pre_busy = m_busy;
            m_err = 0;
            if (pre_busy && out_ready) begin
                void'(beat_q.pop_front());
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    if (beat_q.size() == 0) m_done = 1;
                end
            end else if (load_i && !pre_busy) begin
                build(pset_i);
                m_done = 0;
            end else if (evt_i && !pre_busy) begin
                if (m_done) m_err = 1;
                else begin
                    m_busy = 1;
                    m_left = ev_q.pop_front();
                end
            end
        end
    end

    task automatic chk1(input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            vectors++;
            chk1("valid", 32'(out_valid), 32'(m_busy));
            chk1("done", 32'(done_o), 32'(m_done));
            chk1("err", 32'(err_o), 32'(m_err));
            if (m_busy && out_valid && beat_q.size() > 0) begin
                chk1("src", out_src, beat_q[0][63:32]);
                chk1("dst", out_dst, beat_q[0][31:0]);
                chk1("len", 32'(out_len), 32'(m_len));
                chk1("width", 32'(out_width), 32'(m_width));
            end
        end
    end

    function automatic logic [255:0] mk(input logic [31:0] opt, input logic [31:0] src,
        input logic [31:0] dst, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
        input logic [15:0] rld, input logic [15:0] sb, input logic [15:0] db,
        input logic [15:0] sc, input logic [15:0] dc);
        logic [255:0] p;
        p = '0;
        p[31:0] = opt; p[63:32] = src; p[95:64] = {b, a}; p[127:96] = dst;
        p[159:128] = {db, sb}; p[191:160] = {rld, 16'hFFFF}; p[223:192] = {dc, sc};
        p[239:224] = c;
        return p;
    endfunction

    task automatic do_load(input logic [255:0] p);
        @(negedge clk); pset_i = p; load_i = 1;
        @(negedge clk); load_i = 0;
    endtask

    task automatic fire;
        @(negedge clk); evt_i = 1;
        @(negedge clk); evt_i = 0;
    endtask

    // events until complete; stall_on makes ready drop periodically
    task automatic run_block(input bit stall_on);
        int guard = 0;
        while (!m_done && guard < 200) begin
            fire();
            while (m_busy) begin
                @(negedge clk);
                out_ready = stall_on ? ((vectors % 3) != 0) : 1'b1;
            end
            @(negedge clk); out_ready = 1;
            guard++;
        end
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; live = 1;
        cur_req = "R1"; repeat (3) @(negedge clk);
        // R8: event with no block pending
        cur_req = "R8"; fire(); repeat (2) @(negedge clk);
        // R3 R4: A-sync, negative strides, reload 2
        cur_req = "R4";
        do_load(mk(32'h0, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd3, 16'd2,
                   16'd8, 16'hFFFC, 16'hFFEC, 16'd100));
        run_block(1'b1);
        cur_req = "R8"; fire(); fire(); repeat (2) @(negedge clk);
        // R5: AB-sync, stalls, load and event while busy ignored (R2)
        cur_req = "R5";
        do_load(mk(32'h1, 32'h2000, 32'h9000, 16'd16, 16'd3, 16'd3, 16'd7,
                   16'd16, 16'hFFF0, 16'd64, 16'hFF00));
        fire();
        cur_req = "R2";
        @(negedge clk); out_ready = 0; load_i = 1;
        pset_i = mk(32'h0, 32'hDEAD0000, 32'h0, 16'd1, 16'd1, 16'd1, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0);
        evt_i = 1;
        @(negedge clk); load_i = 0; evt_i = 0; out_ready = 1;
        cur_req = "R5"; run_block(1'b1);
        // R6 R10: source held (FIFO), width 5
        cur_req = "R6";
        do_load(mk(32'h0000_0502, 32'h4000_0000, 32'h100, 16'd8, 16'd2, 16'd2, 16'd3,
                   16'd4, 16'd8, 16'd40, 16'd80));
        run_block(1'b0);
        cur_req = "R10";
        do_load(mk(32'h0000_0305, 32'h44, 32'h88, 16'd2, 16'd4, 16'd2, 16'd1,
                   16'd0, 16'd0, 16'd0, 16'd0));
        run_block(1'b1);
        // R6: zero strides, no hold bits
        cur_req = "R6";
        do_load(mk(32'h1, 32'hC0, 32'hE0, 16'd4, 16'd2, 16'd2, 16'd2,
                   16'd0, 16'd0, 16'd0, 16'd0));
        run_block(1'b0);
        // R7 R3: single array block
        cur_req = "R7";
        do_load(mk(32'h0, 32'h10, 32'h20, 16'd1, 16'd1, 16'd1, 16'd1,
                   16'd1, 16'd1, 16'd1, 16'd1));
        run_block(1'b0);
        cur_req = "R3";
        do_load(mk(32'h0, 32'h500, 32'h600, 16'd12, 16'd4, 16'd1, 16'd4,
                   16'd12, 16'd12, 16'd0, 16'd0));
        run_block(1'b1);
        cur_req = "R8"; fire(); repeat (3) @(negedge clk);
        live = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule